// File: doc/BRIEF.md
# Neighbouring-Pin Short Check Controller

This block sequences a one-shot diagnostic that looks for shorts between neighbouring output pins of a 24-channel LED sink driver. A single-cycle check strobe (meant to be issued while every output channel is off) starts the sequence. The controller then raises an enable to the analog short detectors, passes on the selected test-current level, and waits a detection window whose length is set by a one-bit time setting and counted in clock cycles. On the last cycle of that window it samples the 24 per-pin detect inputs and records the outcome.

The outcome is stored as a 3-bit result code and a 24-bit per-pin failure map, both readable at any time. Pass and fail use two distinct non-zero codes, so any other non-zero value after a check shows the checker itself is broken. A failed check pulls an active-low error output low. That output stays low through later checks. It releases only when a clear command arrives while the controller is idle and no detector reports a short.

Top module: `nbr_short_check`

## Requirements
- R1: After reset the result code is 3'b000, the failure map is all zeros, err_n is 1, and busy and det_en are 0.
- R2: A chk_start pulse sampled while busy is 0 drives busy and det_en high from the next cycle. They stay high for exactly the detection window and fall in the cycle after the sampling edge.
- R3: The window is WIN_BASE_US microseconds of CLK_HZ cycles when win_long is 0, and twice that when win_long is 1 (100 or 200 cycles at the 10 MHz default). short_in is sampled only on the final cycle of the window.
- R4: If no short_in bit is high at sampling, the result code becomes 3'b011 and the failure map becomes all zeros.
- R5: If any short_in bit is high at sampling, the result code becomes 3'b110 and the failure map copies short_in bit for bit. Bits 0-7 are red outputs 0-7, bits 8-15 are green outputs 0-7, and bits 16-23 are blue outputs 0-7.
- R6: A failing check drives err_n low in the cycle after sampling. err_n stays low through any later passing check.
- R7: err_clr releases err_n (high in the next cycle) only when busy is 0 and every short_in bit is 0. In all other cases err_clr has no effect. err_clr never alters the result code or the failure map.
- R8: chk_start pulses while busy is 1 are ignored: the window neither restarts nor lengthens.
- R9: test_cur_sel takes the value of cur_high at the accepted start pulse (0 = lower current, 1 = doubled current) and holds it until the next accepted start. Changes to cur_high or win_long during a check have no effect on that check.
- R10: The result code and failure map change only on the sampling edge or on reset. The result code only ever takes the values 3'b000, 3'b011 or 3'b110.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chk_start | input | 1 | Check-command strobe |
| err_clr | input | 1 | Error-clear command strobe |
| win_long | input | 1 | Detection time select (0 base, 1 double) |
| cur_high | input | 1 | Test current select (0 low, 1 high) |
| short_in | input | 24 | Per-pin short detector outputs |
| det_en | output | 1 | Enables the analog detectors during the window |
| test_cur_sel | output | 1 | Test current level for the analog sources |
| busy | output | 1 | High while a check is in progress |
| res_code | output | 3 | Latched result code |
| fail_map | output | 24 | Latched per-pin failure map |
| err_n | output | 1 | Sticky active-low error output |

## Verification
The bench sets short_in only on the last window cycle, and in another run only before it. A design that samples early or late would record a pass for the first and a fail for the second. Stray start pulses and setting changes are sent in the middle of a check. A design that restarted or re-read its settings would show a longer window or a changed test_cur_sel. The bench also runs a passing check after a failing one and sends a clear while a short is still present. A non-sticky error output would rise too early in either case. Shorts that span the red/green and green/blue group borders check that no bit of the map is shifted or swapped.

// File: rtl/nbr_short_pkg.sv
package nbr_short_pkg;

    localparam int unsigned CODE_W = 3;

    localparam logic [CODE_W-1:0] CODE_NONE = 3'b000;
    localparam logic [CODE_W-1:0] CODE_PASS = 3'b011;
    localparam logic [CODE_W-1:0] CODE_FAIL = 3'b110;

    localparam int unsigned COLOUR_GROUPS = 3;
    localparam int unsigned PINS_PER_GROUP = 8;

endpackage

// File: rtl/nbr_short_timer.sv
module nbr_short_timer #(
    parameter int unsigned CLK_HZ      = 10_000_000,
    parameter int unsigned WIN_BASE_US = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic long_i,
    input  logic run_i,
    output logic last_o
);

    localparam int unsigned BASE_CYC = (CLK_HZ / 1_000_000) * WIN_BASE_US;
    localparam int unsigned LONG_CYC = 2 * BASE_CYC;
    localparam int unsigned CW       = $clog2(LONG_CYC + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = long_i ? CW'(LONG_CYC - 1) : CW'(BASE_CYC - 1);
        end else if (run_i && cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign last_o = run_i && (cnt_q == '0);

    initial begin
        assert (BASE_CYC >= 1);
    end

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(LONG_CYC - 1)); // R3

    AST_CNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        run_i && !load_i && cnt_q != '0 |=> cnt_q == $past(cnt_q) - 1'b1); // R3

endmodule

// File: rtl/nbr_short_result.sv
module nbr_short_result
    import nbr_short_pkg::*;
#(
    parameter int unsigned NUM_PINS = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                done_i,
    input  logic                busy_i,
    input  logic                clr_i,
    input  logic [NUM_PINS-1:0] short_i,
    output logic [CODE_W-1:0]   code_o,
    output logic [NUM_PINS-1:0] map_o,
    output logic                err_n_o
);

    typedef struct packed {
        logic [CODE_W-1:0]   code;
        logic [NUM_PINS-1:0] map;
        logic                fault;
    } res_state_t;

    res_state_t st_d, st_q;
    logic       any_short;
    logic       clr_ok;

    assign any_short = |short_i;
    assign clr_ok    = clr_i && !busy_i && !any_short;

    always_comb begin
        st_d = st_q;
        if (done_i) begin
            st_d.code = any_short ? CODE_FAIL : CODE_PASS;
            st_d.map  = short_i;
            if (any_short) begin
                st_d.fault = 1'b1;
            end
        end else if (clr_ok) begin
            st_d.fault = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{code: CODE_NONE, map: '0, fault: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign code_o  = st_q.code;
    assign map_o   = st_q.map;
    assign err_n_o = ~st_q.fault;

    AST_FAIL_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        done_i && any_short |=> !err_n_o && code_o == CODE_FAIL); // R6

    AST_PASS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        code_o == CODE_PASS |-> map_o == '0); // R4

    AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        code_o == CODE_NONE || code_o == CODE_PASS || code_o == CODE_FAIL); // R10

    AST_CLR_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        !err_n_o && (any_short || busy_i || !clr_i) |=> !err_n_o); // R7

    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done_i |=> $stable(code_o) && $stable(map_o)); // R10

endmodule

// File: rtl/nbr_short_check.sv
module nbr_short_check
    import nbr_short_pkg::*;
#(
    parameter int unsigned CLK_HZ      = 10_000_000,
    parameter int unsigned WIN_BASE_US = 10,
    parameter int unsigned NUM_PINS    = COLOUR_GROUPS * PINS_PER_GROUP
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                chk_start,
    input  logic                err_clr,
    input  logic                win_long,
    input  logic                cur_high,
    input  logic [NUM_PINS-1:0] short_in,
    output logic                det_en,
    output logic                test_cur_sel,
    output logic                busy,
    output logic [CODE_W-1:0]   res_code,
    output logic [NUM_PINS-1:0] fail_map,
    output logic                err_n
);

    typedef struct packed {
        logic busy;
        logic cur;
    } seq_state_t;

    seq_state_t seq_d, seq_q;
    logic       start_ok;
    logic       win_last;

    assign start_ok = chk_start && !seq_q.busy;

    always_comb begin
        seq_d = seq_q;
        if (start_ok) begin
            seq_d.busy = 1'b1;
            seq_d.cur  = cur_high;
        end else if (win_last) begin
            seq_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{busy: 1'b0, cur: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    nbr_short_timer #(
        .CLK_HZ      (CLK_HZ),
        .WIN_BASE_US (WIN_BASE_US)
    ) timer_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (start_ok),
        .long_i (win_long),
        .run_i  (seq_q.busy),
        .last_o (win_last)
    );

    nbr_short_result #(
        .NUM_PINS (NUM_PINS)
    ) result_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .done_i  (win_last),
        .busy_i  (seq_q.busy),
        .clr_i   (err_clr),
        .short_i (short_in),
        .code_o  (res_code),
        .map_o   (fail_map),
        .err_n_o (err_n)
    );

    assign busy         = seq_q.busy;
    assign det_en       = seq_q.busy;
    assign test_cur_sel = seq_q.cur;

    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && chk_start |=> busy && det_en); // R2

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        win_last |=> !busy); // R2

    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        busy && chk_start |=> $stable(test_cur_sel)); // R8

    AST_CUR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && chk_start |=> test_cur_sel == $past(cur_high)); // R9

endmodule

// File: tb/nbr_short_check_tb_top.sv
module nbr_short_check_tb_top;

    localparam int unsigned CLK_HZ   = 10_000_000;
    localparam int unsigned BASE_US  = 10;
    localparam int unsigned WIN_S    = (CLK_HZ / 1_000_000) * BASE_US;
    localparam int unsigned WIN_L    = 2 * WIN_S;
    localparam logic [2:0]  C_PASS   = 3'b011;
    localparam logic [2:0]  C_FAIL   = 3'b110;

    // {win_long, cur_high, short pattern, expected code}
    localparam int unsigned NV = 6;
    localparam logic [28:0] VEC [0:NV-1] = '{
        {1'b0, 1'b0, 24'h000000, 3'b011},
        {1'b1, 1'b1, 24'h000003, 3'b110},
        {1'b0, 1'b1, 24'h018000, 3'b110},
        {1'b1, 1'b0, 24'h000000, 3'b011},
        {1'b0, 1'b0, 24'h000180, 3'b110},
        {1'b1, 1'b1, 24'hC00000, 3'b110}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chk_start = 1'b0;
    logic        err_clr = 1'b0;
    logic        win_long = 1'b0;
    logic        cur_high = 1'b0;
    logic [23:0] short_in = '0;
    logic        det_en, test_cur_sel, busy, err_n;
    logic [2:0]  res_code;
    logic [23:0] fail_map;

    int errors = 0;
    int checks = 0;
    logic done = 1'b0;
    logic err_exp;

    always #2 clk = ~clk;

    nbr_short_check #(
        .CLK_HZ      (CLK_HZ),
        .WIN_BASE_US (BASE_US)
    ) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .chk_start    (chk_start),
        .err_clr      (err_clr),
        .win_long     (win_long),
        .cur_high     (cur_high),
        .short_in     (short_in),
        .det_en       (det_en),
        .test_cur_sel (test_cur_sel),
        .busy         (busy),
        .res_code     (res_code),
        .fail_map     (fail_map),
        .err_n        (err_n)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk) chk_start = 1'b1;
        @(negedge clk) chk_start = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk) err_clr = 1'b1;
        @(negedge clk) err_clr = 1'b0;
    endtask

    task automatic count_busy(output int n);
        n = 0;
        while (busy && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 code", 32'(res_code), 32'h0);
        check("R1 map", 32'(fail_map), 32'h0);
        check("R1 err_n", 32'(err_n), 32'h1);
        check("R1 busy/det_en", {30'h0, busy, det_en}, 32'h0);
        rst_n = 1'b1;
        err_exp = 1'b1;

        // vector table: window, current, result, sticky error
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            win_long = VEC[i][28];
            cur_high = VEC[i][27];
            short_in = VEC[i][26:3];
            pulse_start();
            check("R2 det_en raised", 32'(det_en), 32'h1);
            check("R9 test_cur_sel", 32'(test_cur_sel), 32'(VEC[i][27]));
            count_busy(n);
            check("R3 window length", 32'(n), VEC[i][28] ? WIN_L : WIN_S);
            check("R2 det_en dropped", 32'(det_en), 32'h0);
            check(VEC[i][2:0] == C_PASS ? "R4 code" : "R5 code", 32'(res_code), 32'(VEC[i][2:0]));
            check(VEC[i][2:0] == C_PASS ? "R4 map" : "R5 map", 32'(fail_map), 32'(VEC[i][26:3]));
            if (VEC[i][2:0] == C_FAIL) err_exp = 1'b0;
            check("R6 err_n", 32'(err_n), 32'(err_exp));
        end

        // R7: clear with short still present has no effect
        short_in = 24'h000100;
        pulse_clr();
        check("R7 blocked err_n", 32'(err_n), 32'h0);
        check("R7 blocked code", 32'(res_code), 32'(C_FAIL));
        check("R7 blocked map", 32'(fail_map), 32'hC00000);
        // R7: clear with short gone releases err_n, results kept
        short_in = '0;
        pulse_clr();
        check("R7 released err_n", 32'(err_n), 32'h1);
        check("R7 code kept", 32'(res_code), 32'(C_FAIL));
        check("R7 map kept", 32'(fail_map), 32'hC00000);

        // R3: short present only on final window cycle -> fail
        win_long = 1'b0;
        short_in = '0;
        pulse_start();
        repeat (WIN_S - 1) @(negedge clk);
        short_in = 24'h00C000;
        @(negedge clk);
        short_in = '0;
        check("R3 final-cycle busy", 32'(busy), 32'h0);
        check("R3 final-cycle sample", 32'(fail_map), 32'h00C000);
        check("R6 fail after final sample", 32'(err_n), 32'h0);

        // R7: clear during a check is ignored even with no short
        pulse_start();
        pulse_clr();
        check("R7 clear while busy", 32'(err_n), 32'h0);
        count_busy(n);

        // R3: short only before final cycle -> pass
        short_in = 24'hFFFFFF;
        pulse_start();
        repeat (WIN_S - 1) @(negedge clk);
        short_in = '0;
        @(negedge clk);
        check("R3 early short ignored", 32'(res_code), 32'(C_PASS));
        check("R3 early short map", 32'(fail_map), 32'h0);
        check("R6 err sticky after pass", 32'(err_n), 32'h0);

        // R8 / R9: restart strobe and setting changes mid-check ignored
        win_long = 1'b0;
        cur_high = 1'b1;
        pulse_start();
        n = 1;
        win_long = 1'b1;
        cur_high = 1'b0;
        while (busy && n < 1000) begin
            chk_start = (n == 5);
            n++;
            @(negedge clk);
        end
        chk_start = 1'b0;
        check("R8 restart ignored", 32'(n - 1), WIN_S);
        check("R9 cur held", 32'(test_cur_sel), 32'h1);

        // R10: results hold while idle with changing inputs
        short_in = 24'h5A5A5A;
        repeat (20) @(negedge clk);
        check("R10 code hold", 32'(res_code), 32'(C_PASS));
        check("R10 map hold", 32'(fail_map), 32'h0);
        short_in = '0;

        // R1: reset in the middle of a check
        short_in = 24'h000001;
        pulse_start();
        repeat (10) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid reset busy", 32'(busy), 32'h0);
        check("R1 mid reset code", 32'(res_code), 32'h0);
        check("R1 mid reset err_n", 32'(err_n), 32'h1);
        rst_n = 1'b1;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule